// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Path

The controller gathers 32 level-sensitive interrupt lines, latches their levels every clock, and filters the maskable ones through an enable mask that software writes over a small word-addressed register bus. Towards the processor it drives one request line and an 8-bit vector bus. When exactly one enabled source is pending, the vector identifies that source. When several are pending, the controller does not choose between them in hardware: it emits a shared vector, and software reads the pending registers to make the choice.

The two highest-numbered lines do not pass through the mask. They set bits in a separate status register, and the OR of those bits drives a dedicated non-maskable output. Line 0 has no pending bit. All outputs are registered. Register reads return data one cycle after the read strobe.

Top module: `vic_nmi_ctrl`

## Requirements
- R1: The register word index is `bus_addr >> 2`. A read strobe at a clock edge loads `bus_rdata` with the register value from before that edge: index 0 gives the mask, 1 the raw pending word, 2 the masked pending word, 3 the non-maskable status, and 4 (and any higher index) gives zero. `bus_rdata` holds its value while no read is strobed.
- R2: Only index 0 (the mask) is writable. A write to index 1, 2, 3 or 4 leaves the mask unchanged and has no effect on any output.
- R3: Each input line n with 1 ≤ n ≤ 29 drives bit n−1 of the raw pending word at its current level. Line 0 is ignored, and raw pending bits 29 to 31 always read zero.
- R4: Input lines 30 and 31 drive bits 30 and 31 of the non-maskable status word. `cpu_nmi` is the OR of those bits, and the mask has no effect on it.
- R5: The masked pending word always equals the raw pending word ANDed with the mask.
- R6: If exactly one masked pending bit i is set (bits 0 to 30 examined), `cpu_vector` is 0x31 + i.
- R7: If the lowest set masked pending bit has another set bit above it, `cpu_vector` is 0x30.
- R8: With no masked pending bit set, `cpu_vector` is 0. `cpu_irq` is high exactly when `cpu_vector` is nonzero.
- R9: `cpu_vector`, `cpu_irq` and `cpu_nmi` change at the same clock edge that samples a new input level or performs a mask write, and at no other edge.
- R10: Active-low reset clears the mask, the pending and status words, and `bus_rdata`, so `cpu_irq` and `cpu_nmi` are low and `cpu_vector` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt lines |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after the strobe |
| cpu_irq | output | 1 | Maskable interrupt request |
| cpu_vector | output | 8 | Interrupt vector |
| cpu_nmi | output | 1 | Non-maskable interrupt request |

## Verification
On every cycle, the assertions check the following:
- `cpu_irq` agrees with a nonzero vector, and the vector stays within its legal set of values.
- `cpu_nmi` follows the two top lines one cycle later, whatever the mask holds.
- Non-mask writes leave the mask alone.
- The unused raw bits stay at zero.
- Masked and diagnostic reads return the right values.

The exact vector for a given pending pattern, the choice between the shared vector and a single-source vector, and the timing of each output change can only be shown by the bench's scenarios. Those scenarios are checked against a behavioural model on every clock.

// File: rtl/vic_pkg.sv
// Shared constants and register index encoding for the interrupt controller.
// Assumes a 32-bit data bus and word-granular register access.
package vic_pkg;
    localparam int DATA_W    = 32;
    localparam int VEC_W     = 8;
    localparam int NMI_FIRST = 30;           // first line routed to the NMI path
    localparam int SCAN_BITS = 31;           // masked bits examined by the encoder
    localparam logic [VEC_W-1:0] VEC_SHARED = 8'h30;
    localparam logic [VEC_W-1:0] VEC_FIRST  = 8'h31;

    typedef enum logic [2:0] {
        IDX_MASK   = 3'd0,
        IDX_RAW    = 3'd1,
        IDX_MASKED = 3'd2,
        IDX_NMI    = 3'd3,
        IDX_DIAG   = 3'd4
    } reg_idx_e;
endpackage

// File: rtl/vic_input_latch.sv
// Samples the interrupt lines each clock and splits them into the
// maskable pending word (line n -> bit n-1) and the NMI status word
// (line n -> bit n). Line 0 is dropped. Presents next-state values
// so the top can register its outputs in the same edge.
module vic_input_latch
    import vic_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  lines,
    output logic [DATA_W-1:0] raw_d,
    output logic [DATA_W-1:0] nmi_d,
    output logic [DATA_W-1:0] raw_q,
    output logic [DATA_W-1:0] nmi_q
);
    // Route each line to its pending or status bit.
    for (genvar n = 0; n < DATA_W; n++) begin : g_route
        if (n >= 1 && n < NMI_FIRST && n < LINES) begin : g_mask_src
            assign raw_d[n-1] = lines[n];
        end
        if (n >= NMI_FIRST && n < LINES) begin : g_nmi_src
            assign nmi_d[n] = lines[n];
        end else begin : g_nmi_zero
            assign nmi_d[n] = 1'b0;
        end
        if (n >= NMI_FIRST - 1 || n + 1 >= LINES) begin : g_raw_zero
            assign raw_d[n] = 1'b0;
        end
    end

    // Hold the sampled words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
            nmi_q <= '0;
        end else begin
            raw_q <= raw_d;
            nmi_q <= nmi_d;
        end
    end
endmodule

// File: rtl/vic_vector_enc.sv
// Combinational vector encoder. It finds the lowest set bit among the
// scanned bits and checks whether any further bit is set. A single
// source gives VEC_FIRST + index, several give VEC_SHARED, none gives 0.
module vic_vector_enc
    import vic_pkg::*;
#(
    parameter int SCAN = SCAN_BITS
) (
    input  logic [DATA_W-1:0] pend,
    output logic [VEC_W-1:0]  vector
);
    localparam int IDX_W = $clog2(SCAN);

    logic [IDX_W-1:0] low_idx;
    logic             any_set;
    logic             many_set;

    // Find the lowest set bit and whether a second bit exists.
    always_comb begin
        low_idx  = '0;
        any_set  = 1'b0;
        many_set = 1'b0;
        for (int b = SCAN - 1; b >= 0; b--) begin
            if (pend[b]) begin
                if (any_set) many_set = 1'b1;
                any_set = 1'b1;
                low_idx = IDX_W'(b);
            end
        end
    end

    // Form the vector value.
    always_comb begin
        if (!any_set)     vector = '0;
        else if (many_set) vector = VEC_SHARED;
        else              vector = VEC_FIRST + VEC_W'(low_idx);
    end
endmodule

// File: rtl/vic_regfile.sv
// Register decode: holds the mask, handles writes to index 0 only, and
// returns the selected register through a registered read port.
module vic_regfile
    import vic_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] raw_q,
    input  logic [DATA_W-1:0] nmi_q,
    output logic [DATA_W-1:0] mask_d,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] rd_sel;

    assign idx = bus_addr[ADDR_W-1:2];

    // Next mask: only index 0 is writable.
    always_comb begin
        mask_d = mask_q;
        if (bus_wr && idx == IDX_W'(IDX_MASK)) mask_d = bus_wdata;
    end

    // Read select over the current register contents.
    always_comb begin
        case (idx)
            IDX_W'(IDX_MASK):   rd_sel = mask_q;
            IDX_W'(IDX_RAW):    rd_sel = raw_q;
            IDX_W'(IDX_MASKED): rd_sel = raw_q & mask_q;
            IDX_W'(IDX_NMI):    rd_sel = nmi_q;
            default:            rd_sel = '0;
        endcase
    end

    // Mask storage and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            bus_rdata <= '0;
        end else begin
            mask_q <= mask_d;
            if (bus_rd) bus_rdata <= rd_sel;
        end
    end
endmodule

// File: rtl/vic_nmi_ctrl.sv
// Top of the vectored interrupt controller. Combines the line latch, the
// register file and the vector encoder, and registers the CPU-facing
// outputs from next-state values so they move with the causing edge.
module vic_nmi_ctrl
    import vic_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq,
    output logic [VEC_W-1:0]  cpu_vector,
    output logic              cpu_nmi
);
    logic [DATA_W-1:0] raw_d, raw_q, nmi_d, nmi_q, mask_d, mask_q;
    logic [DATA_W-1:0] masked_d;
    logic [VEC_W-1:0]  vec_d;

    vic_input_latch #(.LINES(LINES)) u_latch (
        .clk(clk), .rst_n(rst_n), .lines(irq_in),
        .raw_d(raw_d), .nmi_d(nmi_d), .raw_q(raw_q), .nmi_q(nmi_q)
    );

    vic_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .raw_q(raw_q), .nmi_q(nmi_q),
        .mask_d(mask_d), .mask_q(mask_q), .bus_rdata(bus_rdata)
    );

    assign masked_d = raw_d & mask_d;

    vic_vector_enc #(.SCAN(SCAN_BITS)) u_enc (
        .pend(masked_d), .vector(vec_d)
    );

    // Register the CPU-facing request, vector and NMI.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_irq    <= 1'b0;
            cpu_vector <= '0;
            cpu_nmi    <= 1'b0;
        end else begin
            cpu_irq    <= |masked_d[SCAN_BITS-1:0];
            cpu_vector <= vec_d;
            cpu_nmi    <= |nmi_d;
        end
    end
endmodule

// File: rtl/vic_nmi_ctrl_sva.sv
// Checker for vic_nmi_ctrl. It is attached through bind and observes ports
// plus the mask and raw pending registers.
module vic_nmi_ctrl_sva (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] irq_in,
    input logic [4:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_rdata,
    input logic        cpu_irq,
    input logic [7:0]  cpu_vector,
    input logic        cpu_nmi,
    input logic [31:0] mask_q,
    input logic [31:0] raw_q
);
    // R8: the request agrees with a nonzero vector
    a_r8_irq_vec: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (cpu_vector != 8'h00));

    // R6 / R7: the vector is 0, the shared value, or a single-source value
    a_r6_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_vector == 8'h00 || cpu_vector == 8'h30 ||
        (cpu_vector >= 8'h31 && cpu_vector <= 8'h4D));

    // R4: NMI follows lines 30/31 one edge later, independent of the mask
    a_r4_nmi_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cpu_nmi == $past(irq_in[31] | irq_in[30]));

    // R2: writes outside index 0 leave the mask alone
    a_r2_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[4:2] != 3'd0) |=> mask_q == $past(mask_q));

    // R3: raw pending bits 29..31 never set
    a_r3_raw_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        raw_q[31:29] == 3'b000);

    // R5: a masked read returns raw AND mask
    a_r5_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[4:2] == 3'd2) |=> bus_rdata == $past(raw_q & mask_q));

    // R1: the diagnostic index reads zero
    a_r1_diag_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[4:2] == 3'd4) |=> bus_rdata == 32'h0);
endmodule

bind vic_nmi_ctrl vic_nmi_ctrl_sva u_sva (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .cpu_vector(cpu_vector), .cpu_nmi(cpu_nmi),
    .mask_q(mask_q), .raw_q(raw_q)
);

// File: tb/vic_nmi_ctrl_test.sv
module vic_nmi_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;
    logic [7:0]  cpu_vector;
    logic        cpu_nmi;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Behavioural reference state
    logic [31:0] m_mask, m_raw, m_nmi, m_rdata;
    logic [7:0]  m_vec;
    logic        m_irq, m_nmi_o;

    always #4 clk = ~clk;   // 125 MHz

    vic_nmi_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .cpu_vector(cpu_vector),
        .cpu_nmi(cpu_nmi)
    );

    function automatic logic [7:0] ref_vector(input logic [31:0] p);
        int cnt = 0;
        int low = -1;
        for (int b = 0; b < 31; b++) begin
            if (p[b]) begin
                cnt++;
                if (low < 0) low = b;
            end
        end
        if (cnt == 0) return 8'h00;
        if (cnt > 1)  return 8'h30;
        return 8'(8'h31 + low);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one clock, update the model, and compare every output.
    task automatic tick();
        logic [31:0] sel;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_mask = 0; m_raw = 0; m_nmi = 0; m_rdata = 0;
            m_vec = 0; m_irq = 0; m_nmi_o = 0;
        end else begin
            case (int'(bus_addr) / 4)
                0: sel = m_mask;
                1: sel = m_raw;
                2: sel = m_raw & m_mask;
                3: sel = m_nmi;
                default: sel = 0;
            endcase
            if (bus_rd) m_rdata = sel;
            m_raw = 0;
            for (int n = 1; n < 30; n++) m_raw[n-1] = irq_in[n];
            m_nmi = {irq_in[31:30], 30'h0};
            if (bus_wr && int'(bus_addr) / 4 == 0) m_mask = bus_wdata;
            m_vec   = ref_vector(m_raw & m_mask);
            m_irq   = (m_vec != 0);
            m_nmi_o = (m_nmi != 0);
        end
        check("R9 vector", 32'(cpu_vector), 32'(m_vec));
        check("R9 irq",    32'(cpu_irq),    32'(m_irq));
        check("R9 nmi",    32'(cpu_nmi),    32'(m_nmi_o));
        check("R1 rdata",  bus_rdata,       m_rdata);
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 5'(idx * 4); bus_wdata = d; bus_wr = 1;
        tick();
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        @(negedge clk);
        bus_addr = 5'(idx * 4); bus_rd = 1;
        tick();
        v = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic lines(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        tick();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        tick(); tick();
        // R10: reset state
        check("R10 vector", 32'(cpu_vector), 0);
        check("R10 irq", 32'(cpu_irq), 0);
        check("R10 nmi", 32'(cpu_nmi), 0);
        @(negedge clk); rst_n = 1;
        tick();
        rd(0, v); check("R10 mask zero", v, 0);

        // R9: a line change alone does not move outputs before the edge
        wr(0, 32'hFFFF_FFFF);
        @(negedge clk); irq_in = 32'h0000_0002; #1;
        check("R9 no early change", 32'(cpu_vector), 0);
        tick();
        check("R6 line1 -> 0x31", 32'(cpu_vector), 32'h31);
        lines(32'h2000_0000);
        check("R6 line29 -> 0x4D", 32'(cpu_vector), 32'h4D);
        lines(32'h0001_0000);
        check("R6 line16 -> 0x40", 32'(cpu_vector), 32'h40);

        // R3: line 0 ignored
        lines(32'h0000_0001);
        check("R3 line0 vector", 32'(cpu_vector), 0);
        rd(1, v); check("R3 line0 raw", v, 0);

        // R7: several pending give the shared vector
        lines(32'h0000_0106);
        check("R7 shared", 32'(cpu_vector), 32'h30);
        check("R8 irq on shared", 32'(cpu_irq), 1);

        // R5: mask narrows to one source
        wr(0, 32'h0000_0080);
        check("R6 masked single", 32'(cpu_vector), 32'h38);
        rd(2, v); check("R5 masked read", v, 32'h0000_0080);
        rd(1, v); check("R3 raw read", v, 32'h0000_0083);

        // R8: everything masked
        wr(0, 32'h0);
        check("R8 vector zero", 32'(cpu_vector), 0);
        check("R8 irq low", 32'(cpu_irq), 0);

        // R4: NMI lines ignore the mask
        lines(32'h4000_0000);
        check("R4 nmi line30", 32'(cpu_nmi), 1);
        lines(32'h8000_0000);
        rd(3, v); check("R4 nmi status", v, 32'h8000_0000);
        check("R4 nmi no vector", 32'(cpu_vector), 0);
        lines(32'h0);
        check("R4 nmi cleared", 32'(cpu_nmi), 0);

        // R2: writes to read-only indices ignored
        wr(0, 32'h0000_00F0);
        for (int i = 1; i < 5; i++) wr(i, 32'hFFFF_FFFF);
        rd(0, v); check("R2 mask unchanged", v, 32'h0000_00F0);
        lines(32'h0000_0002);
        check("R2 no unmask", 32'(cpu_vector), 0);

        // R1: diagnostic and out-of-range indices read zero
        lines(32'hFFFF_FFFF);
        rd(4, v); check("R1 diag zero", v, 0);
        rd(7, v); check("R1 high index zero", v, 0);

        // R10: reset in mid-operation
        @(negedge clk); rst_n = 0;
        tick();
        check("R10 reset vector", 32'(cpu_vector), 0);
        check("R10 reset nmi", 32'(cpu_nmi), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule